// File: doc/BRIEF.md
# Command Packet Receive FIFO

This block collects a command packet sent by a host, one byte per data-port write, and keeps it until a local microprocessor reads it out. The packet is 12 bytes deep. The microprocessor drains it by reading one fixed address again and again. Host writes land in the FIFO only while a routing select bit points the data port at it. Reading an empty FIFO returns the constant FFh and changes nothing.

Some commands carry parameter blocks shorter than 12 bytes, so the completion point can be programmed. Each rising edge of the data-request bit captures a 4-bit length field as the threshold and also starts a fresh packet. When the stored byte count reaches the threshold, two things happen. An active-low transfer-end flag goes low, and an active-high packet-complete flag goes high. From that point on the host can add no more bytes until the next request edge. An active-low not-empty flag tells the microprocessor that at least one byte is waiting.

Top module: `cmd_pkt_fifo`

## Requirements
- R1: After reset the FIFO is empty, the threshold is 12, `pkt_done` is 0, `tend_n` and `nempty_n` are 1, and `rd_data` reads FFh.
- R2: A host write (`host_wr` high at a clock edge) stores `host_data` only if `sel_pkt` is high in that cycle. Otherwise it has no effect.
- R3: Bytes leave in the order they were written. `rd_data` always shows the oldest stored byte, and a cycle with `rd_en` high on a non-empty FIFO removes that byte at the clock edge.
- R4: While the FIFO is empty, `rd_data` is FFh and a read changes no state.
- R5: On a 0-to-1 transition of `drq` (sampled at clock edges), `thr_field` is captured as the threshold. While `drq` stays high, later changes of `thr_field` are not captured.
- R6: A captured value of 0 or greater than 12 becomes a threshold of 12.
- R7: `pkt_done` rises in the cycle after an accepted write brings the count to the threshold or above. It stays high until reset or the next `drq` rising edge. `tend_n` is low exactly while the count is at or above the threshold.
- R8: While `pkt_done` is high, host writes are dropped even if `sel_pkt` is high.
- R9: `nempty_n` is low exactly while at least one byte is stored.
- R10: A `drq` rising edge empties the FIFO and clears `pkt_done`. Any write or read in that same cycle is ignored.
- R11: A read and an accepted write in the same cycle leave the count unchanged and keep the byte order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_pkt | input | 1 | Routes host data-port writes to the FIFO |
| host_wr | input | 1 | Host data-port write strobe |
| host_data | input | 8 | Host write byte |
| drq | input | 1 | Data-request control bit. Its rising edge arms a new packet |
| thr_field | input | 4 | Length field captured as the threshold |
| rd_en | input | 1 | Microprocessor read strobe at the FIFO address |
| rd_data | output | 8 | Oldest stored byte, or FFh when empty |
| tend_n | output | 1 | Active-low: count has reached the threshold |
| pkt_done | output | 1 | Packet complete; further writes blocked |
| nempty_n | output | 1 | Active-low: FIFO holds at least one byte |

## Verification
The bench builds the block with its default depth of 12 and an 8-bit data path. This makes the 4-bit length field able to express 0 and 13 to 15, so the clamp to 12 is reachable. The same values let a full-packet threshold fill every slot, so both pointers wrap past the last entry. Simultaneous read and write traffic at thresholds below the depth exercises wrap-around at every offset.

// File: rtl/cpf_pkg.sv
package cpf_pkg;

  // Threshold normalization: zero or anything beyond depth means full depth.
  function automatic int thr_clamp(input int raw, input int depth);
    return ((raw == 0) || (raw > depth)) ? depth : raw;
  endfunction

  // Circular pointer advance.
  function automatic int ptr_step(input int p, input int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // Fill level after one cycle of pushes and pops.
  function automatic int level_next(input int lvl, input bit push, input bit pop);
    return lvl + int'(push) - int'(pop);
  endfunction

endpackage

// File: rtl/cpf_thresh.sv
module cpf_thresh #(
  parameter int DEPTH = 12,
  parameter int TW    = 4,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          drq,
  input  logic [TW-1:0] thr_field,
  output logic          drq_rise,
  output logic [LW-1:0] thr_lvl
);
  import cpf_pkg::*;

  logic drq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drq_q <= 1'b0;
    else        drq_q <= drq;
  end

  assign drq_rise = drq & ~drq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        thr_lvl <= LW'(DEPTH);
    else if (drq_rise) thr_lvl <= LW'(thr_clamp(int'(thr_field), DEPTH));
  end

  AST_THR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_lvl != '0) && (thr_lvl <= LW'(DEPTH))); // R6

  AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    drq && drq_q |=> $stable(thr_lvl)); // R5

endmodule

// File: rtl/cpf_store.sv
module cpf_store #(
  parameter int DEPTH = 12,
  parameter int DW    = 8,
  parameter logic [DW-1:0] EMPTY_VAL = '1,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level
);
  import cpf_pkg::*;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push) wptr <= PW'(ptr_step(int'(wptr), DEPTH));
      if (pop)  rptr <= PW'(ptr_step(int'(rptr), DEPTH));
      level <= LW'(level_next(int'(level), push, pop));
    end
  end

  assign rdata = (level == '0) ? EMPTY_VAL : mem[rptr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop |-> level < LW'(DEPTH)); // R8

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> level != '0); // R4

endmodule

// File: rtl/cmd_pkt_fifo.sv
module cmd_pkt_fifo #(
  parameter int DEPTH = 12,
  parameter int DW    = 8,
  parameter int TW    = 4,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_pkt,
  input  logic          host_wr,
  input  logic [DW-1:0] host_data,
  input  logic          drq,
  input  logic [TW-1:0] thr_field,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          tend_n,
  output logic          pkt_done,
  output logic          nempty_n
);
  import cpf_pkg::*;

  logic          drq_rise;
  logic [LW-1:0] thr_lvl;
  logic [LW-1:0] level;
  logic [LW-1:0] level_nx;
  logic          wr_acc;
  logic          rd_pop;
  logic          thr_hit;

  cpf_thresh #(.DEPTH(DEPTH), .TW(TW)) u_thr (
    .clk       (clk),
    .rst_n     (rst_n),
    .drq       (drq),
    .thr_field (thr_field),
    .drq_rise  (drq_rise),
    .thr_lvl   (thr_lvl)
  );

  assign wr_acc   = host_wr & sel_pkt & ~pkt_done & (level < LW'(DEPTH)) & ~drq_rise;
  assign rd_pop   = rd_en & (level != '0) & ~drq_rise;
  assign level_nx = LW'(level_next(int'(level), wr_acc, rd_pop));
  assign thr_hit  = wr_acc & (level_nx >= thr_lvl);

  cpf_store #(.DEPTH(DEPTH), .DW(DW), .EMPTY_VAL('1)) u_st (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (drq_rise),
    .push  (wr_acc),
    .pop   (rd_pop),
    .wdata (host_data),
    .rdata (rd_data),
    .level (level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pkt_done <= 1'b0;
    else if (drq_rise) pkt_done <= 1'b0;
    else if (thr_hit)  pkt_done <= 1'b1;
  end

  assign tend_n   = ~(level >= thr_lvl);
  assign nempty_n = (level == '0);

  AST_NOSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_pkt && !rd_en && !drq_rise |=> level == $past(level)); // R2

  AST_DONE_BLOCKS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done && host_wr && !rd_en && !drq_rise |=> level == $past(level)); // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done && !drq_rise |=> pkt_done); // R7

  AST_CLR_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    drq_rise |=> (level == '0) && !pkt_done); // R10

  AST_RW_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc && rd_pop |=> level == $past(level)); // R11

endmodule

// File: tb/sim_cmd_pkt_fifo.sv
module sim_cmd_pkt_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_pkt = 1'b0, host_wr = 1'b0, drq = 1'b0, rd_en = 1'b0;
  logic [7:0] host_data = 8'h00;
  logic [3:0] thr_field = 4'h0;
  logic [7:0] rd_data;
  logic       tend_n, pkt_done, nempty_n;

  int errors = 0, checks = 0;
  bit done_flag = 0;

  logic [7:0] q[$];
  int thr_m = 12;
  bit done_m = 0;
  bit drq_m = 0;

  always #4 clk = ~clk;

  cmd_pkt_fifo u0 (
    .clk(clk), .rst_n(rst_n), .sel_pkt(sel_pkt), .host_wr(host_wr),
    .host_data(host_data), .drq(drq), .thr_field(thr_field), .rd_en(rd_en),
    .rd_data(rd_data), .tend_n(tend_n), .pkt_done(pkt_done), .nempty_n(nempty_n)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit wr, input bit sel, input logic [7:0] d,
                            input bit rd, input bit drq_i, input logic [3:0] t);
    if (drq_i && !drq_m) begin
      thr_m  = (t == 0 || t > 12) ? 12 : int'(t);
      q.delete();
      done_m = 0;
    end else begin
      bit popn, acc;
      popn = rd && (q.size() > 0);
      acc  = wr && sel && !done_m && (q.size() < 12);
      if (popn) void'(q.pop_front());
      if (acc) begin
        q.push_back(d);
        if (q.size() >= thr_m) done_m = 1;
      end
    end
    drq_m = drq_i;
  endtask

  task automatic compare();
    if (q.size() > 0) check("R3 rd_data", rd_data, q[0]);
    else              check("R4 rd_data", rd_data, 8'hFF);
    check("R9 nempty_n", nempty_n, (q.size() == 0));
    check("R7 tend_n", tend_n, !(q.size() >= thr_m));
    check("R7 pkt_done", pkt_done, done_m);
  endtask

  task automatic cyc(input bit wr, input bit sel, input logic [7:0] d,
                     input bit rd, input bit drq_i, input logic [3:0] t);
    host_wr = wr; sel_pkt = sel; host_data = d; rd_en = rd; drq = drq_i; thr_field = t;
    @(posedge clk);
    model_step(wr, sel, d, rd, drq_i, t);
    @(negedge clk);
    compare();
  endtask

  task automatic arm(input logic [3:0] t);
    cyc(0, 1, 8'h00, 0, 0, t);
    cyc(0, 1, 8'h00, 0, 1, t);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rd_data", rd_data, 8'hFF);
    check("R1 nempty_n", nempty_n, 1);
    check("R1 tend_n", tend_n, 1);
    check("R1 pkt_done", pkt_done, 0);

    // R2 writes with select low ignored
    for (int i = 0; i < 5; i++) cyc(1, 0, 8'h10 + 8'(i), 0, 0, 0);
    check("R2 nempty_n", nempty_n, 1);

    // R6 threshold 0 -> 12, fill completely, pointers reach end
    arm(4'd0);
    for (int i = 0; i < 12; i++) begin
      check("R7 pkt_done before fill", pkt_done, 0);
      cyc(1, 1, 8'hA0 + 8'(i), 0, 1, 0);
    end
    check("R6 pkt_done at 12", pkt_done, 1);
    check("R7 tend_n at 12", tend_n, 0);
    // R8 writes dropped while done
    for (int i = 0; i < 3; i++) cyc(1, 1, 8'h55, 0, 1, 0);
    // R3 drain in order
    for (int i = 0; i < 12; i++) begin
      check("R3 order", rd_data, 8'hA0 + 8'(i));
      cyc(0, 0, 8'h00, 1, 1, 0);
    end
    // R4 empty reads
    for (int i = 0; i < 2; i++) cyc(0, 0, 8'h00, 1, 1, 0);
    check("R4 empty read", rd_data, 8'hFF);
    check("R7 done sticky", pkt_done, 1);

    // R5, R8 threshold 5: only five of seven writes taken
    arm(4'd5);
    check("R10 cleared", pkt_done, 0);
    for (int i = 0; i < 7; i++) cyc(1, 1, 8'h30 + 8'(i), 0, 1, 4'd9);
    check("R5 pkt_done thr 5", pkt_done, 1);
    for (int i = 0; i < 5; i++) cyc(0, 0, 8'h00, 1, 1, 0);
    check("R8 extra dropped", nempty_n, 1);

    // R6 threshold 14 -> 12
    arm(4'd14);
    for (int i = 0; i < 11; i++) cyc(1, 1, 8'h60 + 8'(i), 0, 1, 0);
    check("R6 not done at 11", pkt_done, 0);
    cyc(1, 1, 8'h6B, 0, 1, 0);
    check("R6 done at 12", pkt_done, 1);

    // R11 simultaneous read and write
    arm(4'd0);
    for (int i = 0; i < 3; i++) cyc(1, 1, 8'h70 + 8'(i), 0, 1, 0);
    for (int i = 0; i < 20; i++) cyc(1, 1, 8'h80 + 8'(i), 1, 1, 0);
    check("R11 order", rd_data, 8'h91);

    // R10 rising edge with a write in the same cycle
    cyc(1, 1, 8'hEE, 0, 0, 0);
    cyc(1, 1, 8'hEE, 1, 1, 4'd3);
    check("R10 empty", nempty_n, 1);
    check("R10 rd_data", rd_data, 8'hFF);

    // Random traffic
    for (int i = 0; i < 600; i++) begin
      bit d_i;
      d_i = ($urandom_range(0, 15) == 0) ? ~drq : drq;
      cyc(1'($urandom), 1'($urandom_range(0, 3) != 0), 8'($urandom), 1'($urandom),
          d_i, 4'($urandom));
    end

    finish_run();
  end
endmodule